// File: doc/BRIEF.md
# Edge-Latched Address Static RAM

This block is a 2048-word by 8-bit static memory. It is driven by three active-low strobes: a chip enable, a write enable and an output enable. All strobes are sampled on a fast system clock, and their edges are found from the sampled history. The address does not have to stay on the pins for the whole cycle. It is captured into an internal register when the chip enable falls. After that the address pins may carry other traffic, such as a multiplexed address/data bus, without disturbing the cycle in progress.

A write runs from the enable's falling edge to whichever of the write strobe or the chip enable rises first. The data on the input bus at that rising edge is the data stored. When the write strobe is held low across several enable cycles, each enable rise stores its own word at its own latched address. The bidirectional data bus is split into an input, an output and an output-valid flag, so no tristate logic is needed.

The array is arranged as 128 rows of 128 bits. The upper seven address bits select a row. The lower four select one of sixteen columns inside each bit's slice of the row.

Top module: `edge_latch_sram`

## Requirements
- R1: The address is taken from `addr` only when the sampled `ce_n` falls (high to low) in an accepted cycle. Later changes on `addr` do not alter the location read or written in that cycle.
- R2: `dout_en` is high only while a cycle is active, `ce_n` is low, `oe_n` is low and `we_n` is high, after the synchroniser delay. While `dout_en` is low, `dout` is all zeros.
- R3: While `oe_n` is high, `dout_en` stays low, including during a whole write cycle.
- R4: A write ended by `we_n` rising while `ce_n` is low stores the `din` value present at that rise at the latched address.
- R5: A write ended by `ce_n` rising while `we_n` is still low stores the `din` value present at that rise.
- R6: With `we_n` held low over several enable cycles, each rise of `ce_n` stores the `din` value of that moment at that cycle's own latched address.
- R7: At most one store occurs per enable cycle. After `we_n` has ended a write, a further low pulse on `we_n` before `ce_n` rises stores nothing.
- R8: A falling `ce_n` that comes before `ce_n` has been sampled high for MIN_HIGH clocks (default 4) is ignored. In that case no address is latched, `dout_en` stays low and no store takes place.
- R9: All 2048 locations are independent. The upper 7 address bits pick the row and the lower 4 bits pick the column, so words that differ only in row bits or only in column bits keep separate values.
- R10: After reset, `dout_en` is low and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low; falling edge latches address |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Word address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` would drive the shared bus |

## Verification
The hardest situation to reach from the ports is an enable cycle that carries more than one write-strobe edge, or a chip-enable fall that comes too soon after the previous rise. Both need strobe waveforms no ordinary read or write produces. The stimulus builds them directly. It pulses the write strobe twice inside one enable window, raises and drops the enable after a single clock of high time, and holds the write strobe low across several enable cycles. Afterwards it reads each affected location back through a normal cycle, so the stored word shows which edge, if any, took effect.

// File: rtl/esram_pkg.sv
package esram_pkg;
    localparam int ADDR_W_DEF   = 11;
    localparam int DATA_W_DEF   = 8;
    localparam int COL_BITS_DEF = 4;
    localparam int MIN_HIGH_DEF = 4;

    // position of each strobe inside the sampled strobe vector
    typedef enum int {
        STB_CE = 0,
        STB_WE = 1,
        STB_OE = 2
    } stb_idx_e;

    localparam int NUM_STB = 3;
endpackage

// File: rtl/esram_strobe_sync.sv
module esram_strobe_sync #(
    parameter int NUM_STB = 3,
    parameter int BUS_W   = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STB-1:0] stb_raw,
    input  logic [BUS_W-1:0]   bus_raw,
    output logic [NUM_STB-1:0] stb_lvl,
    output logic [NUM_STB-1:0] stb_prev,
    output logic [NUM_STB-1:0] stb_fall,
    output logic [NUM_STB-1:0] stb_rise,
    output logic [BUS_W-1:0]   bus_smp
);
    typedef struct packed {
        logic [NUM_STB-1:0] s1;
        logic [NUM_STB-1:0] s2;
        logic [BUS_W-1:0]   bus;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = stb_raw;
        st_d.s2  = st_q.s1;
        st_d.bus = bus_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1  <= '1;
            st_q.s2  <= '1;
            st_q.bus <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NUM_STB; i++) begin : g_edge
        assign stb_fall[i] = st_q.s2[i] & ~st_q.s1[i];
        assign stb_rise[i] = ~st_q.s2[i] & st_q.s1[i];
    end

    assign stb_lvl  = st_q.s1;
    assign stb_prev = st_q.s2;
    assign bus_smp  = st_q.bus;
endmodule

// File: rtl/esram_ctrl.sv
module esram_ctrl #(
    parameter int ADDR_W   = 11,
    parameter int MIN_HIGH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lvl,
    input  logic              we_lvl,
    input  logic              oe_lvl,
    input  logic              we_prev,
    input  logic              ce_fall,
    input  logic              ce_rise,
    input  logic              we_rise,
    input  logic [ADDR_W-1:0] addr_s,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic              wr_en,
    output logic              rd_en,
    output logic              cyc_o
);
    localparam int CNT_W = $clog2(MIN_HIGH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_HIGH);

    typedef struct packed {
        logic              cyc;
        logic              done;
        logic              en;
        logic [CNT_W-1:0]  hi_cnt;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  accept;
    logic  store;

    always_comb begin
        st_d   = st_q;
        accept = ce_fall && (st_q.hi_cnt >= CNT_MAX);

        // a write ends on the first rising W or E edge, once per cycle
        store = st_q.cyc && !st_q.done &&
                ((ce_rise && !we_prev) || (we_rise && !ce_lvl));

        if (ce_lvl) begin
            if (st_q.hi_cnt < CNT_MAX) st_d.hi_cnt = st_q.hi_cnt + 1'b1;
        end else begin
            st_d.hi_cnt = '0;
        end

        if (store) st_d.done = 1'b1;

        if (accept) begin
            st_d.cyc  = 1'b1;
            st_d.done = 1'b0;
            st_d.addr = addr_s;
        end else if (ce_rise) begin
            st_d.cyc = 1'b0;
        end

        st_d.en = st_d.cyc && !ce_lvl && !oe_lvl && we_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cyc    <= 1'b0;
            st_q.done   <= 1'b0;
            st_q.en     <= 1'b0;
            st_q.hi_cnt <= CNT_MAX;
            st_q.addr   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q_o = st_q.addr;
    assign wr_en    = store;
    assign rd_en    = st_q.en;
    assign cyc_o    = st_q.cyc;
endmodule

// File: rtl/esram_array.sv
module esram_array #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int COL_BITS = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROW_BITS = ADDR_W - COL_BITS;
    localparam int ROWS     = 2 ** ROW_BITS;
    localparam int COLS     = 2 ** COL_BITS;
    localparam int ROW_W    = DATA_W * COLS;

    logic [ROW_W-1:0]    mem [ROWS];
    logic [ROW_BITS-1:0] row;
    logic [COL_BITS-1:0] col;

    assign row = addr[ADDR_W-1:COL_BITS];
    assign col = addr[COL_BITS-1:0];

    // each data bit owns a COLS-wide slice of the row
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < DATA_W; b++) begin
                mem[row][b*COLS + int'(col)] <= wdata[b];
            end
        end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_rd
        assign rdata[b] = mem[row][b*COLS + int'(col)];
    end
endmodule

// File: rtl/edge_latch_sram.sv
module edge_latch_sram
    import esram_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int COL_BITS = COL_BITS_DEF,
    parameter int MIN_HIGH = MIN_HIGH_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [NUM_STB-1:0] stb_raw, stb_lvl, stb_prev, stb_fall, stb_rise;
    logic [BUS_W-1:0]   bus_smp;
    logic [ADDR_W-1:0]  addr_s, addr_q;
    logic [DATA_W-1:0]  din_s, rdata;
    logic               wr_en, rd_en, cyc;
    logic               ce_lvl, oe_lvl, ce_fall;

    assign stb_raw[STB_CE] = ce_n;
    assign stb_raw[STB_WE] = we_n;
    assign stb_raw[STB_OE] = oe_n;

    esram_strobe_sync #(
        .NUM_STB (NUM_STB),
        .BUS_W   (BUS_W)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_raw  (stb_raw),
        .bus_raw  ({addr, din}),
        .stb_lvl  (stb_lvl),
        .stb_prev (stb_prev),
        .stb_fall (stb_fall),
        .stb_rise (stb_rise),
        .bus_smp  (bus_smp)
    );

    assign addr_s  = bus_smp[BUS_W-1:DATA_W];
    assign din_s   = bus_smp[DATA_W-1:0];
    assign ce_lvl  = stb_lvl[STB_CE];
    assign oe_lvl  = stb_lvl[STB_OE];
    assign ce_fall = stb_fall[STB_CE];

    esram_ctrl #(
        .ADDR_W   (ADDR_W),
        .MIN_HIGH (MIN_HIGH)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_lvl   (stb_lvl[STB_CE]),
        .we_lvl   (stb_lvl[STB_WE]),
        .oe_lvl   (stb_lvl[STB_OE]),
        .we_prev  (stb_prev[STB_WE]),
        .ce_fall  (stb_fall[STB_CE]),
        .ce_rise  (stb_rise[STB_CE]),
        .we_rise  (stb_rise[STB_WE]),
        .addr_s   (addr_s),
        .addr_q_o (addr_q),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .cyc_o    (cyc)
    );

    esram_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .COL_BITS (COL_BITS)
    ) u_array (
        .clk   (clk),
        .wr_en (wr_en),
        .addr  (addr_q),
        .wdata (din_s),
        .rdata (rdata)
    );

    assign dout_en = rd_en;
    assign dout    = rd_en ? rdata : '0;
endmodule

// File: rtl/esram_checker.sv
module esram_checker #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_lvl,
    input logic              oe_lvl,
    input logic              ce_fall,
    input logic              wr_en,
    input logic              cyc,
    input logic [ADDR_W-1:0] addr_q,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0); // R2
    AST_CE_GATES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_lvl |=> !dout_en); // R2
    AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_lvl |=> !dout_en); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> $stable(addr_q)); // R1
    AST_SINGLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R7
    AST_STORE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cyc); // R8
endmodule

bind edge_latch_sram esram_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_lvl  (ce_lvl),
    .oe_lvl  (oe_lvl),
    .ce_fall (ce_fall),
    .wr_en   (wr_en),
    .cyc     (cyc),
    .addr_q  (addr_q),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/edge_latch_sram_tb.sv
module edge_latch_sram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    edge_latch_sram u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // {is_write, address, data}
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 11'h000, 8'hA5}, {1'b1, 11'h00F, 8'h3C},
        {1'b1, 11'h7F0, 8'hC3}, {1'b1, 11'h7FF, 8'h5A},
        {1'b1, 11'h123, 8'h11}, {1'b1, 11'h456, 8'h22},
        {1'b0, 11'h000, 8'hA5}, {1'b0, 11'h00F, 8'h3C},
        {1'b0, 11'h7F0, 8'hC3}, {1'b0, 11'h7FF, 8'h5A},
        {1'b0, 11'h123, 8'h11}, {1'b0, 11'h456, 8'h22}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // write ended by W rising while E is low; G held high (R3, R4)
    task automatic wr_w(input logic [10:0] a, input logic [7:0] d);
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = 8'hEE;
        tick(2); addr = ~a;                      // R1: address may move
        tick(1); din = d;
        tick(2); check("R3", {8'h00, dout_en}, 9'h000);
        tick(1); we_n = 1;
        tick(2); din = 8'h99;
        tick(1); ce_n = 1;
        tick(6);
    endtask

    // normal read cycle, address changes after latching (R1, R2)
    task automatic rd(input string req, input logic [10:0] a, input logic [7:0] d);
        ce_n = 0; we_n = 1; oe_n = 0; addr = a;
        tick(2); addr = a ^ 11'h2A5;
        tick(3);
        check(req, {dout, dout_en}, {d, 1'b1});
        ce_n = 1; oe_n = 1;
        tick(3);
        check("R2", {dout, dout_en}, 9'h000);
        tick(3);
    endtask

    initial begin
        tick(3);
        check("R10", {dout, dout_en}, 9'h000);
        rst_n = 1;
        tick(4);
        check("R10", {dout, dout_en}, 9'h000);

        // vector table: R9 row/column independence, R4 W-ended writes
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) wr_w(VEC[i][18:8], VEC[i][7:0]);
            else rd("R9", VEC[i][18:8], VEC[i][7:0]);
        end

        // R2: G low but W low gives no output
        ce_n = 0; we_n = 0; oe_n = 0; addr = 11'h123; din = 8'h11;
        tick(5); check("R2", {dout, dout_en}, 9'h000);
        we_n = 1; tick(2); ce_n = 1; oe_n = 1; tick(6);

        // R5: write ended by E rising with W still low
        ce_n = 0; we_n = 0; addr = 11'h200; din = 8'h00;
        tick(3); din = 8'h6D;
        tick(3); ce_n = 1;
        tick(2); we_n = 1; din = 8'hFF;
        tick(6);
        rd("R5", 11'h200, 8'h6D);

        // R6: W low across three E cycles
        we_n = 0;
        for (int k = 0; k < 3; k++) begin
            ce_n = 0; addr = 11'h300 + 11'(k); din = 8'h00;
            tick(3); din = 8'h80 + 8'(k);
            tick(3); ce_n = 1;
            tick(6);
        end
        we_n = 1; tick(2);
        for (int k = 0; k < 3; k++) rd("R6", 11'h300 + 11'(k), 8'h80 + 8'(k));

        // R7: second W pulse in one E cycle is not stored
        ce_n = 0; we_n = 0; addr = 11'h0AB; din = 8'h4E;
        tick(3); we_n = 1;
        tick(3); din = 8'hB1; we_n = 0;
        tick(3); we_n = 1;
        tick(3); ce_n = 1;
        tick(6);
        rd("R7", 11'h0AB, 8'h4E);

        // R8: E fall after too short a high time is ignored
        wr_w(11'h555, 8'h77);
        ce_n = 0; we_n = 1; oe_n = 1; addr = 11'h123;
        tick(4); ce_n = 1;
        tick(1); ce_n = 0; oe_n = 0; addr = 11'h555;
        tick(5); check("R8", {dout, dout_en}, 9'h000);
        oe_n = 1; we_n = 0; din = 8'h0C;
        tick(3); we_n = 1;
        tick(2); ce_n = 1;
        tick(6);
        rd("R8", 11'h555, 8'h77);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule